// File: doc/BRIEF.md
# Cycle-Prescaled Scanline Interrupt Timer

This block is a cartridge-side interrupt timer driven by CPU register writes. Address decoding happens upstream, so three write strobes arrive with a shared data byte. One strobe sets the reload value. One sets a mode byte that holds the enable bit, an enable-after-acknowledge bit and a count-source bit. The third acknowledges the interrupt. An 8-bit up-counter raises a level interrupt request when it is clocked at its maximum value, and on that clock it reloads itself from the reload register.

The counter has two clock sources. In scanline mode a prescaler approximates video scanlines from CPU cycles: it loses 3 units on each CPU cycle and gains 341 units each time it runs out, so the counter steps once per 341/3 CPU cycles on average. In cycle mode the prescaler is bypassed and the counter steps on every CPU cycle. The CPU cycle itself arrives as a one-cycle enable on the block clock.

Top module: `scanIrqTimer`

## Requirements
- R1: After reset the interrupt output is low, and the mode byte, reload value and counter are all zero, so counting is disabled.
- R2: A reload-register write stores the data byte. It does not change the running count and takes effect at the next reload.
- R3: A mode write stores the whole byte. If bit 1 of the new byte is set, the counter loads the reload value and the prescaler restarts at 341.
- R4: Any mode write clears a pending interrupt, whatever the byte written.
- R5: An acknowledge write clears a pending interrupt and copies mode bit 0 into mode bit 1. Mode bit 2 and the other bits keep their values.
- R6: With mode bit 2 clear, each CPU cycle takes 3 from the prescaler. When the result would be zero or less, the prescaler gains 341 instead and the counter steps once. From a restart, the counter steps after 114, 114 and 113 CPU cycles, and that pattern repeats.
- R7: With mode bit 2 set, the counter steps on every CPU cycle.
- R8: A step taken at 0xFF loads the reload value into the counter and raises the interrupt. Any other step adds one. An enable write with reload value L therefore gives an interrupt after 256-L steps, and again every 256-L steps after that.
- R9: Counting and prescaling happen only on CPU cycles while mode bit 1 is set. The interrupt stays high until a mode or acknowledge write clears it.
- R10: No counting takes place in a cycle that carries a mode or acknowledge write. A reload-register write in the same cycle as an overflow leaves the counter with the previous reload value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuTick | input | 1 | One-cycle pulse for each CPU cycle |
| wrLatch | input | 1 | Write strobe for the reload value |
| wrMode | input | 1 | Write strobe for the mode byte |
| wrAck | input | 1 | Write strobe for the acknowledge |
| wrData | input | 8 | Data byte shared by all three strobes |
| irqOut | output | 1 | Level interrupt request |

## Verification
The interrupt output is the only observable of this block, so a wrong internal state appears as an interrupt edge on the wrong CPU cycle. The fault becomes visible at the next overflow, which is up to 256 steps later, or about 29,000 CPU cycles in scanline mode. For that reason the bench compares the output on every cycle against an independent model, and it also measures the exact number of CPU cycles to each interrupt across sweeps of reload values in both modes. Faults in the prescaler phase show up as a shift of one cycle in the 114/114/113 pattern. Faults in acknowledge or mode handling show up as an interrupt that either fails to clear or keeps firing after the timer has been disabled.

// File: rtl/scanIrqPkg.sv
package scanIrqPkg;
  // Per-cycle commands from the control unit to the counting datapath
  typedef struct packed {
    logic cntLoad;  // load counter from reload register
    logic cntStep;  // advance counter by one step
    logic irqClr;   // drop the pending request
  } tmrStrobe_t;

  // Mode byte bit positions
  localparam int ACK_EN_BIT = 0;
  localparam int RUN_EN_BIT = 1;
  localparam int CYC_MODE_BIT = 2;
endpackage

// File: rtl/scanIrqCtrl.sv
module scanIrqCtrl
  import scanIrqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_RELOAD = 341,
  parameter int PRE_STEP = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTick,
  input  logic              wrMode,
  input  logic              wrAck,
  input  logic [DATA_W-1:0] wrData,
  output tmrStrobe_t        strb
);
  localparam int PRE_W = $clog2(PRE_RELOAD + 1);
  localparam logic [PRE_W-1:0] PRE_INIT = PRE_W'(PRE_RELOAD);
  localparam logic [PRE_W-1:0] PRE_DEC = PRE_W'(PRE_STEP);
  localparam logic [PRE_W-1:0] PRE_WRAP = PRE_W'(PRE_RELOAD - PRE_STEP);

  logic [DATA_W-1:0] modeReg;
  logic [PRE_W-1:0]  preCnt;
  logic              runEn;
  logic              cycMode;
  logic              anyWrite;
  logic              preExpire;
  logic              preAdvance;

  assign runEn      = modeReg[RUN_EN_BIT];
  assign cycMode    = modeReg[CYC_MODE_BIT];
  assign anyWrite   = wrMode | wrAck;
  assign preExpire  = (preCnt <= PRE_DEC);
  assign preAdvance = cpuTick && runEn && !cycMode && !anyWrite;

  always_comb begin
    strb = '0;
    if (wrMode) begin
      strb.irqClr  = 1'b1;
      strb.cntLoad = wrData[RUN_EN_BIT];
    end else if (wrAck) begin
      strb.irqClr = 1'b1;
    end else if (cpuTick && runEn) begin
      strb.cntStep = cycMode ? 1'b1 : preExpire;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeReg <= '0;
    end else if (wrMode) begin
      modeReg <= wrData;
    end else if (wrAck) begin
      modeReg[RUN_EN_BIT] <= modeReg[ACK_EN_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= PRE_INIT;
    end else if (wrMode && wrData[RUN_EN_BIT]) begin
      preCnt <= PRE_INIT;
    end else if (preAdvance) begin
      preCnt <= preExpire ? preCnt + PRE_WRAP : preCnt - PRE_DEC;
    end
  end

  // R6
  pre_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (preCnt >= PRE_W'(1)) && (preCnt <= PRE_INIT));

  // R5
  ack_copy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrAck && !wrMode) |=> (modeReg[RUN_EN_BIT] == $past(modeReg[ACK_EN_BIT]))
      && (modeReg[CYC_MODE_BIT] == $past(modeReg[CYC_MODE_BIT])));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!runEn && !wrMode) |=> $stable(preCnt));

  // R10
  write_nostep_chk: assert property (@(posedge clk) disable iff (!rstN)
    anyWrite |-> !strb.cntStep);
endmodule

// File: rtl/scanIrqDatapath.sv
module scanIrqDatapath
  import scanIrqPkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrLatch,
  input  logic [DATA_W-1:0] wrData,
  input  tmrStrobe_t        strb,
  output logic              irqOut
);
  localparam logic [DATA_W-1:0] CNT_TOP = '1;

  logic [DATA_W-1:0] reloadReg;
  logic [DATA_W-1:0] cntReg;
  logic              irqReg;
  logic              cntWrap;

  assign cntWrap = strb.cntStep && (cntReg == CNT_TOP);
  assign irqOut  = irqReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reloadReg <= '0;
    end else if (wrLatch) begin
      reloadReg <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntReg <= '0;
    end else if (strb.cntLoad || cntWrap) begin
      cntReg <= reloadReg;
    end else if (strb.cntStep) begin
      cntReg <= cntReg + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqReg <= 1'b0;
    end else if (strb.irqClr) begin
      irqReg <= 1'b0;
    end else if (cntWrap) begin
      irqReg <= 1'b1;
    end
  end

  // R8
  irq_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqReg) |-> ($past(strb.cntStep) && ($past(cntReg) == CNT_TOP)));

  // R4
  irq_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.irqClr |=> !irqReg);

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntLoad |=> (cntReg == $past(reloadReg)));

  // R10
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.cntLoad && strb.cntStep));
endmodule

// File: rtl/scanIrqTimer.sv
module scanIrqTimer
  import scanIrqPkg::*;
#(
  parameter int DATA_W = 8,
  parameter int PRE_RELOAD = 341,
  parameter int PRE_STEP = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cpuTick,
  input  logic              wrLatch,
  input  logic              wrMode,
  input  logic              wrAck,
  input  logic [DATA_W-1:0] wrData,
  output logic              irqOut
);
  tmrStrobe_t strb;

  scanIrqCtrl #(
    .DATA_W(DATA_W),
    .PRE_RELOAD(PRE_RELOAD),
    .PRE_STEP(PRE_STEP)
  ) uCtrl (
    .clk(clk),
    .rstN(rstN),
    .cpuTick(cpuTick),
    .wrMode(wrMode),
    .wrAck(wrAck),
    .wrData(wrData),
    .strb(strb)
  );

  scanIrqDatapath #(
    .DATA_W(DATA_W)
  ) uData (
    .clk(clk),
    .rstN(rstN),
    .wrLatch(wrLatch),
    .wrData(wrData),
    .strb(strb),
    .irqOut(irqOut)
  );
endmodule

// File: tb/sim_scanIrqTimer.sv
module sim_scanIrqTimer;
  localparam int PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cpuTick = 1'b0;
  logic       wrLatch = 1'b0;
  logic       wrMode = 1'b0;
  logic       wrAck = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       irqOut;

  int checks = 0;
  int fails = 0;

  // reference model state
  logic [7:0] mMode = 8'h00;
  logic [7:0] mLatch = 8'h00;
  logic [7:0] mCnt = 8'h00;
  logic       mIrq = 1'b0;
  int         mPre = 341;

  scanIrqTimer u0 (
    .clk(clk), .rstN(rstN), .cpuTick(cpuTick), .wrLatch(wrLatch),
    .wrMode(wrMode), .wrAck(wrAck), .wrData(wrData), .irqOut(irqOut)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // CPU cycles to 'steps' counter steps in scanline mode: 114,114,113 repeating (R6)
  function automatic int scanTicks(input int steps);
    int t;
    t = (steps / 3) * 341;
    if (steps % 3 >= 1) t += 114;
    if (steps % 3 == 2) t += 114;
    return t;
  endfunction

  task automatic modelStep(input bit tk, input bit wl, input bit wm, input bit wa,
                           input logic [7:0] d);
    bit step;
    logic [7:0] oldLatch;
    step = 1'b0;
    oldLatch = mLatch;
    if (wm) begin
      mMode = d;
      mIrq = 1'b0;
      if (d[1]) begin mCnt = oldLatch; mPre = 341; end
    end else if (wa) begin
      mMode[1] = mMode[0];
      mIrq = 1'b0;
    end else if (tk && mMode[1]) begin
      if (mMode[2]) step = 1'b1;
      else if (mPre <= 3) begin mPre += 338; step = 1'b1; end
      else mPre -= 3;
    end
    if (step) begin
      if (mCnt == 8'hFF) begin mCnt = oldLatch; mIrq = 1'b1; end
      else mCnt = mCnt + 8'd1;
    end
    if (wl) mLatch = d;
  endtask

  task automatic cyc(input bit tk, input bit wl, input bit wm, input bit wa,
                     input logic [7:0] d, input string tag);
    @(negedge clk);
    cpuTick = tk; wrLatch = wl; wrMode = wm; wrAck = wa; wrData = d;
    @(posedge clk);
    modelStep(tk, wl, wm, wa, d);
    #(PERIOD/4);
    chk(tag, int'(irqOut), int'(mIrq));
    @(negedge clk);
    cpuTick = 1'b0; wrLatch = 1'b0; wrMode = 1'b0; wrAck = 1'b0;
  endtask

  task automatic ticksToIrq(input int maxT, input string tag, output int n);
    n = -1;
    for (int i = 1; i <= maxT; i++) begin
      cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, tag);
      if (irqOut) begin n = i; break; end
    end
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog expired checks=%0d", checks);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    int lv [7] = '{255, 254, 250, 200, 128, 64, 0};
    int sv [6] = '{255, 254, 253, 252, 250, 0};

    repeat (4) @(posedge clk);
    #(PERIOD/4);
    chk("R1 reset irq", int'(irqOut), 0);
    rstN = 1'b1;
    // R1: counting disabled after reset; ticks give nothing
    for (int i = 0; i < 300; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R1");
    chk("R1 no irq while disabled", int'(irqOut), 0);

    // R7 and R8: cycle-mode sweep, two periods each, acknowledge keeps mode (R5)
    foreach (lv[k]) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'(lv[k]), "R2");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h07, "R3");
      ticksToIrq(300, "R7", n);
      chk("R7 cycle-mode period", n, 256 - lv[k]);
      for (int i = 0; i < 5; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R9");
      chk("R9 irq holds", int'(irqOut), 1);
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
      chk("R5 ack clears", int'(irqOut), 0);
      ticksToIrq(300, "R8", n);
      chk("R8 R5 reload period after ack", n, 256 - lv[k]);
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
      chk("R4 mode write clears", int'(irqOut), 0);
    end

    // R6: scanline mode sweep
    foreach (sv[k]) begin
      cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'(sv[k]), "R2");
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h03, "R3");
      ticksToIrq(30000, "R6", n);
      chk("R6 scanline period", n, scanTicks(256 - sv[k]));
      if (sv[k] >= 250) begin
        // second period continues prescaler phase from the first
        cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
        ticksToIrq(3000, "R6", n);
        chk("R6 scanline second period",
            n, scanTicks(2 * (256 - sv[k])) - scanTicks(256 - sv[k]) - 1 + 1);
      end
      cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h00, "R4");
    end

    // R5: ack with bit 0 clear disables counting
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'd250, "R2");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h06, "R3");
    ticksToIrq(50, "R5", n);
    chk("R5 setup period", n, 6);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
    ticksToIrq(400, "R5", n);
    chk("R5 ack copies cleared bit0 -> no irq", n, -1);

    // R4: mode write clears irq and restarts count
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h06, "R3");
    ticksToIrq(50, "R4", n);
    chk("R4 period before", n, 6);
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h06, "R4");
    chk("R4 mode write clears irq", int'(irqOut), 0);
    ticksToIrq(50, "R3", n);
    chk("R3 reload from latch on enable", n, 6);

    // R2: latch write mid-count
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'd240, "R2");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h07, "R3");
    for (int i = 0; i < 5; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R2");
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'd250, "R2");
    ticksToIrq(50, "R2", n);
    chk("R2 running count untouched", n, 11);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
    ticksToIrq(50, "R2", n);
    chk("R2 new value at next reload", n, 6);

    // R10: latch write in the overflow cycle keeps old reload value
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'd254, "R2");
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h07, "R3");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R10");
    cyc(1'b1, 1'b1, 1'b0, 1'b0, 8'd200, "R10");
    chk("R10 overflow with latch write", int'(irqOut), 1);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
    ticksToIrq(50, "R10", n);
    chk("R10 old reload value used", n, 2);
    cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00, "R5");
    ticksToIrq(100, "R10", n);
    chk("R10 new reload value next", n, 56);

    // R10: tick during mode write does not count
    cyc(1'b0, 1'b1, 1'b0, 1'b0, 8'd250, "R2");
    cyc(1'b1, 1'b0, 1'b1, 1'b0, 8'h06, "R10");
    ticksToIrq(50, "R10", n);
    chk("R10 no step in write cycle", n, 6);

    // R9: idle cycles without cpuTick do not count
    cyc(1'b0, 1'b0, 1'b1, 1'b0, 8'h06, "R3");
    for (int i = 0; i < 3; i++) cyc(1'b1, 1'b0, 1'b0, 1'b0, 8'h00, "R9");
    for (int i = 0; i < 20; i++) cyc(1'b0, 1'b0, 1'b0, 1'b0, 8'h00, "R9");
    ticksToIrq(50, "R9", n);
    chk("R9 only cpu cycles count", n, 3);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule